// File: doc/BRIEF.md
# Dual-clock FIFO with output-ready flag

This block is a 36-bit first-in first-out buffer that connects two unrelated clock domains. A producer on the write clock offers one word per cycle with a write strobe, and the block accepts it whenever its input-ready flag is high. A consumer on the read clock sees the oldest word in an output register. The output-ready flag qualifies that word, and the consumer takes it with a read strobe.

The read side works in first-word-fall-through style. When the output register is not valid and the memory holds a word, the block moves that word into the register by itself, with no read request. The write pointer reaches the read clock through a two-stage synchronizer, so a word written into an empty buffer shows up on the third read-clock rising edge after the write. That same edge raises output-ready. Both pointers cross the clock boundary in Gray code and carry one wrap bit beyond the address. A comparator on the read side sorts the occupancy it can see into four levels: empty, one word, two words, or more. Total capacity is the memory depth plus the output register.

Top module: `dcf_fifo`

## Requirements
- R1: While `wr_rst` and `rd_rst` are high, `wr_ready` and `rd_ready` are 0 and `rd_data` is all zeros. `wr_ready` is 1 after the first write-clock rising edge that follows the release of reset on an empty buffer.
- R2: A word presented with `wr_en` high on a write-clock edge where `wr_ready` is high is stored. Stored words leave on `rd_data` in the order they were written. The write pointer moves by one Gray-code position per accepted word.
- R3: A write attempted while `wr_ready` is 0 changes nothing. The word never appears on `rd_data`, and the write pointer holds.
- R4: With no reads, the buffer accepts exactly DEPTH+1 words (DEPTH in memory, one in the output register). `wr_ready` is then 0 and returns to 1 after the buffer is drained.
- R5: After a word is written into an empty buffer whose `rd_ready` is 0, `rd_ready` stays 0 after the first and second read-clock rising edges. The third edge raises it and presents the word.
- R6: While `rd_ready` is 0 and the memory holds a word, the next read-clock edge loads that word and raises `rd_ready`, whatever the value of `rd_en`.
- R7: While `rd_ready` is 1 and `rd_en` is 0, `rd_data` and `rd_ready` hold. An edge with `rd_en` high and a word in memory replaces `rd_data` with the next word.
- R8: While `rd_ready` is 0 and the memory is empty, `rd_en` is ignored, and `rd_data` keeps the last word delivered.
- R9: An edge with `rd_ready` and `rd_en` high and an empty memory drops `rd_ready` to 0.
- R10: Under reads at a random rate and back-to-back writes, every accepted word is delivered exactly once, and the buffer ends empty with `rd_ready` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Active-high reset, synchronous to wr_clk |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 36 | Word to write |
| wr_ready | output | 1 | Input-ready: at least one memory location free |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Active-high reset, synchronous to rd_clk |
| rd_en | input | 1 | Read strobe; consumes the word in the output register |
| rd_data | output | 36 | Output register contents |
| rd_ready | output | 1 | Output-ready: rd_data holds an unread word |

## Verification
The hardest state to reach is exact capacity. The write side only sees the read pointer late, so the last free slot opens only after the auto-loaded word has been reported back across the boundary. The stimulus pauses reads, writes one word, and lets the pointers settle. It then writes back-to-back until `wr_ready` falls, counts the words accepted, and tries one more write that must be dropped before draining everything. The three-edge latency is checked by counting read-clock edges from a single write. The two clock periods are chosen so that their edges never coincide, which makes that count deterministic.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int WORD_W    = 36;
    localparam int PTR_MAX_W = 16;

    typedef logic [PTR_MAX_W-1:0] ptr_word_t;
    typedef logic [WORD_W-1:0]    word_t;

    // Occupancy seen by the read side through the synchronized write pointer
    typedef enum logic [1:0] {
        LVL_EMPTY = 2'd0,
        LVL_ONE   = 2'd1,
        LVL_TWO   = 2'd2,
        LVL_MORE  = 2'd3
    } fill_level_e;

    // Output stage: the word and the flag that qualifies it
    typedef struct packed {
        logic  ready;
        word_t word;
    } out_stage_t;

    function automatic ptr_word_t bin_to_gray(input ptr_word_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_word_t gray_to_bin(input ptr_word_t g);
        ptr_word_t b;
        b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
        for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic fill_level_e classify(input ptr_word_t count);
        if (count == '0)                   return LVL_EMPTY;
        else if (count == ptr_word_t'(1))  return LVL_ONE;
        else if (count == ptr_word_t'(2))  return LVL_TWO;
        else                               return LVL_MORE;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem
    import dcf_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t store [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray_sync,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [PW-1:0] wgray,
    output logic          wr_ready
);
    logic [PW-1:0] wbin_q, wbin_nxt, rbin_seen;
    logic          ready_q, push, full_nxt;

    assign rbin_seen = PW'(gray_to_bin(PTR_MAX_W'(rgray_sync)));
    assign push      = wr_en && ready_q;
    assign wbin_nxt  = wbin_q + PW'(push);
    assign full_nxt  = (wbin_nxt - rbin_seen) == PW'(DEPTH);

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wbin_q  <= '0;
            wgray   <= '0;
            ready_q <= 1'b0;
        end else begin
            wbin_q  <= wbin_nxt;
            wgray   <= PW'(bin_to_gray(PTR_MAX_W'(wbin_nxt)));
            ready_q <= !full_nxt;
        end
    end

    assign mem_we    = push;
    assign mem_waddr = wbin_q[AW-1:0];
    assign wr_ready  = ready_q;
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray_sync,
    input  word_t         mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [PW-1:0] rgray,
    output fill_level_e   level,
    output word_t         rd_data,
    output logic          rd_ready
);
    logic [PW-1:0] rbin_q, rbin_inc, wbin_seen, count;
    out_stage_t    out_q;
    logic          avail, load;

    assign wbin_seen = PW'(gray_to_bin(PTR_MAX_W'(wgray_sync)));
    assign count     = wbin_seen - rbin_q;
    assign level     = classify(PTR_MAX_W'(count));
    assign avail     = level != LVL_EMPTY;
    // Fall-through: an invalid output stage refills on its own
    assign load      = avail && (!out_q.ready || rd_en);
    assign rbin_inc  = rbin_q + PW'(1);

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rbin_q <= '0;
            rgray  <= '0;
            out_q  <= '{ready: 1'b0, word: '0};
        end else if (load) begin
            rbin_q      <= rbin_inc;
            rgray       <= PW'(bin_to_gray(PTR_MAX_W'(rbin_inc)));
            out_q.word  <= mem_rdata;
            out_q.ready <= 1'b1;
        end else if (out_q.ready && rd_en) begin
            out_q.ready <= 1'b0;
        end
    end

    assign mem_raddr = rbin_q[AW-1:0];
    assign rd_data   = out_q.word;
    assign rd_ready  = out_q.ready;
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DEPTH       = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_ready
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    word_t         mem_rdata;
    logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;
    fill_level_e   rd_level;

    dcf_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (wr_data),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata)
    );

    dcf_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .wr_clk     (wr_clk),
        .wr_rst     (wr_rst),
        .wr_en      (wr_en),
        .rgray_sync (rgray_ws),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .wgray      (wgray),
        .wr_ready   (wr_ready)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (wgray),
        .q   (wgray_rs)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (rgray),
        .q   (rgray_ws)
    );

    dcf_rd_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
        .rd_clk     (rd_clk),
        .rd_rst     (rd_rst),
        .rd_en      (rd_en),
        .wgray_sync (wgray_rs),
        .mem_rdata  (mem_rdata),
        .mem_raddr  (mem_raddr),
        .rgray      (rgray),
        .level      (rd_level),
        .rd_data    (rd_data),
        .rd_ready   (rd_ready)
    );
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk
    import dcf_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int PW    = 10
) (
    input logic              wr_clk,
    input logic              wr_rst,
    input logic              wr_en,
    input logic              wr_ready,
    input logic [PW-1:0]     wgray,
    input logic [PW-1:0]     rgray,
    input logic [PW-1:0]     rgray_ws,
    input logic              rd_clk,
    input logic              rd_rst,
    input logic              rd_en,
    input logic              rd_ready,
    input logic [WORD_W-1:0] rd_data,
    input fill_level_e       rd_level
);
    logic [PW-1:0] w_fill;
    assign w_fill = PW'(gray_to_bin(PTR_MAX_W'(wgray))) - PW'(gray_to_bin(PTR_MAX_W'(rgray_ws)));

    // R2: write pointer steps one Gray position at a time
    a_r2_wgray_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R2: read pointer steps one Gray position at a time
    a_r2_rgray_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rgray ^ $past(rgray)) <= 1);

    // R3: a refused write leaves the write pointer alone
    a_r3_drop_write: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && !wr_ready) |=> $stable(wgray));

    // R4: occupancy seen by the write side never exceeds the memory depth
    a_r4_no_overflow: assert property (@(posedge wr_clk) disable iff (wr_rst)
        w_fill <= PW'(DEPTH));

    // R6: an invalid output stage with a stored word is refilled at the next edge
    a_r6_autoload: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (!rd_ready && rd_level != LVL_EMPTY) |=> rd_ready);

    // R7: a valid word waits for a read request
    a_r7_hold_valid: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_ready && !rd_en) |=> (rd_ready && $stable(rd_data)));

    // R8: with nothing stored, the idle output stage keeps its word
    a_r8_hold_idle: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (!rd_ready && rd_level == LVL_EMPTY) |=> (!rd_ready && $stable(rd_data)));

    // R9: consuming the last word clears output-ready
    a_r9_last_read: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_ready && rd_en && rd_level == LVL_EMPTY) |=> !rd_ready);

    // R5: output-ready only rises when the comparator reported a stored word
    a_r5_rise_needs_word: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $rose(rd_ready) |-> $past(rd_level != LVL_EMPTY));
endmodule

bind dcf_fifo dcf_fifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .wr_clk   (wr_clk),
    .wr_rst   (wr_rst),
    .wr_en    (wr_en),
    .wr_ready (wr_ready),
    .wgray    (wgray),
    .rgray    (rgray),
    .rgray_ws (rgray_ws),
    .rd_clk   (rd_clk),
    .rd_rst   (rd_rst),
    .rd_en    (rd_en),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .rd_level (rd_level)
);

// File: tb/dcf_fifo_tb.sv
module dcf_fifo_tb;
    localparam int DEPTH = 512;

    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst = 1'b1, rd_rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic [35:0] rd_data;
    logic        wr_ready, rd_ready;

    int unsigned n_checks = 0, n_errors = 0, rd_pct = 0;
    bit          done = 0;
    logic [35:0] sb_q[$];

    dcf_fifo #(.DEPTH(DEPTH)) u_dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data), .rd_ready(rd_ready)
    );

    // 50 MHz write clock; read clock period 28 ns, edges never aligned with it
    always #10 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #14 rd_clk = ~rd_clk;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: offer one word; record it as expected only if it was accepted
    task automatic push(input logic [35:0] d, output bit took);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = d;
        took    = wr_ready;
        @(posedge wr_clk);
        if (took) sb_q.push_back(d);
        #1 wr_en = 1'b0;
    endtask

    // Monitor: chooses rd_en each read cycle and scores every word consumed
    always @(negedge rd_clk) begin
        if (rd_rst) begin
            rd_en = 1'b0;
        end else begin
            rd_en = ($urandom_range(99) < rd_pct);
            if (rd_en && rd_ready) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2", "word delivered with empty scoreboard", rd_data, '0);
                end else begin
                    logic [35:0] exp_w;
                    exp_w = sb_q.pop_front();
                    check(rd_data == exp_w, "R2", "order of delivered words", rd_data, exp_w);
                end
            end
        end
    end

    task automatic drain();
        rd_pct = 100;
        for (int k = 0; k < 5000 && sb_q.size() != 0; k++) @(posedge rd_clk);
        repeat (4) @(posedge rd_clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge wr_clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        bit   took;
        int   accepted;
        logic [35:0] wa, wb, wc;
        wa = 36'hA_1234_5678;
        wb = 36'hB_0F0F_0F0F;
        wc = 36'hC_DEAD_BEEF;

        // R1: reset state
        repeat (5) @(posedge wr_clk);
        #1;
        check(wr_ready == 1'b0, "R1", "wr_ready in reset", 36'(wr_ready), 36'd0);
        check(rd_ready == 1'b0, "R1", "rd_ready in reset", 36'(rd_ready), 36'd0);
        check(rd_data == '0, "R1", "rd_data in reset", rd_data, '0);
        @(negedge wr_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        @(posedge wr_clk);
        #1;
        check(wr_ready == 1'b1, "R1", "wr_ready after release", 36'(wr_ready), 36'd1);
        repeat (4) @(posedge rd_clk);
        #1;
        check(rd_ready == 1'b0, "R1", "rd_ready idle after release", 36'(rd_ready), 36'd0);

        // R5 / R6: three read-clock edges from write to output, no read request
        rd_pct = 0;
        push(wa, took);
        repeat (2) @(posedge rd_clk);
        #1;
        check(rd_ready == 1'b0, "R5", "rd_ready after second edge", 36'(rd_ready), 36'd0);
        @(posedge rd_clk);
        #1;
        check(rd_ready == 1'b1, "R5", "rd_ready on third edge", 36'(rd_ready), 36'd1);
        check(rd_data == wa, "R6", "word loaded without read", rd_data, wa);

        // R7: valid word holds until read, then the next one replaces it
        push(wb, took);
        repeat (6) @(posedge rd_clk);
        #1;
        check(rd_data == wa && rd_ready, "R7", "hold without rd_en", rd_data, wa);
        rd_pct = 100;
        @(posedge rd_clk);
        #1;
        rd_pct = 0;
        check(rd_data == wb && rd_ready, "R7", "read loads next word", rd_data, wb);

        // R9 / R8: consume the last word, then reads with nothing stored
        rd_pct = 100;
        @(posedge rd_clk);
        #1;
        check(rd_ready == 1'b0, "R9", "rd_ready after last read", 36'(rd_ready), 36'd0);
        check(rd_data == wb, "R8", "previous word kept", rd_data, wb);
        repeat (5) @(posedge rd_clk);
        #1;
        check(rd_ready == 1'b0 && rd_data == wb, "R8", "reads ignored while empty", rd_data, wb);
        push(wc, took);
        repeat (2) @(posedge rd_clk);
        #1;
        check(rd_ready == 1'b0, "R5", "rd_ready low with rd_en held", 36'(rd_ready), 36'd0);
        @(posedge rd_clk);
        #1;
        check(rd_ready == 1'b1 && rd_data == wc, "R6", "load with rd_en held high", rd_data, wc);
        drain();

        // R10: random read rate against back-to-back writes
        rd_pct = 55;
        for (int i = 0; i < 300; i++) begin
            push({4'h5, 32'(i) * 32'h9E37_79B1}, took);
        end
        for (int i = 0; i < 100; i++) begin
            push({4'h6, 32'(i) ^ 32'h5A5A_0000}, took);
            repeat ($urandom_range(2)) @(posedge wr_clk);
        end
        drain();
        check(sb_q.size() == 0, "R10", "scoreboard empty after stream", 36'(sb_q.size()), 36'd0);
        check(rd_ready == 1'b0, "R10", "rd_ready low after stream", 36'(rd_ready), 36'd0);

        // R4 / R3: fill to capacity with reads paused
        rd_pct = 0;
        repeat (10) @(posedge wr_clk);
        push(36'h7_0000_0000, took);
        repeat (10) @(posedge wr_clk);
        accepted = 1;
        for (int i = 1; i < DEPTH + 20; i++) begin
            push({4'h7, 32'(i)}, took);
            if (!took) break;
            accepted++;
        end
        repeat (10) @(posedge wr_clk);
        #1;
        check(accepted == DEPTH + 1, "R4", "words accepted until full", 36'(accepted), 36'(DEPTH + 1));
        check(wr_ready == 1'b0, "R4", "wr_ready when full", 36'(wr_ready), 36'd0);
        push(36'hF_FFFF_FFFF, took);
        check(took == 1'b0, "R3", "write refused when full", 36'(took), 36'd0);
        drain();
        check(sb_q.size() == 0, "R3", "all kept words delivered", 36'(sb_q.size()), 36'd0);
        check(rd_ready == 1'b0, "R3", "dropped word never delivered", 36'(rd_ready), 36'd0);
        repeat (5) @(posedge wr_clk);
        #1;
        check(wr_ready == 1'b1, "R4", "wr_ready after drain", 36'(wr_ready), 36'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule